// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a WIDTH-bit register whose contents change on each rising clock edge according to a 2-bit mode input. The four modes are hold, shift toward the least significant end, shift toward the most significant end, and parallel load. Each flip-flop is fed by a four-way selector that picks one of four sources: its own output, its upper neighbour, its lower neighbour, or its parallel data bit.

Two separate serial inputs enter at opposite ends of the register. The bit that a shift pushes out of the register is always visible on a serial output at that end, so several registers can be chained. An asynchronous active-low clear takes priority over every mode.

Top module: `univ_shift_reg`

## Requirements
- R1: With mode 2'b00 (hold), the register keeps its value on the clock edge.
- R2: With mode 2'b01 (shift right), each bit i takes the old value of bit i+1, and bit WIDTH-1 takes `ser_in_msb`.
- R3: With mode 2'b10 (shift left), each bit i takes the old value of bit i-1, and bit 0 takes `ser_in_lsb`.
- R4: With mode 2'b11 (load), the register takes `par_in` in full on the clock edge.
- R5: While `clr_n` is low, the register reads all zeros at once, with no clock edge needed, whatever the mode. After reset it reads zero.
- R6: `ser_out_lsb` always equals bit 0 of the register, which is the bit a right shift drops. `ser_out_msb` always equals bit WIDTH-1, which is the bit a left shift drops.
- R7: Inputs that the current mode does not use have no effect. In hold and load the serial inputs are ignored. In hold and both shift modes `par_in` is ignored.
- R8: WIDTH is a parameter of at least 2, and the mode encoding does not change with it. At WIDTH=2, each serial input lands at its own end and the other bit takes the shifted neighbour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all bits |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_in_msb | input | 1 | Serial bit entering the top bit on a right shift |
| ser_in_lsb | input | 1 | Serial bit entering bit 0 on a left shift |
| par_in | input | WIDTH | Parallel load data |
| q | output | WIDTH | Register contents |
| ser_out_lsb | output | 1 | Bit 0, the bit leaving on a right shift |
| ser_out_msb | output | 1 | Top bit, the bit leaving on a left shift |

## Verification
The bench builds two copies of the block.

- **WIDTH=4:** this copy runs a vector table that moves through every mode. The table reverses shift direction on patterns that are not symmetric, so a bit taken from the wrong neighbour shows up. It also sets the unused serial and parallel inputs to values that would change the result if they leaked through.
- **WIDTH=2:** this is the smallest legal width. Here each end bit is the other's only neighbour, so an error in the end-of-register wiring at either end becomes visible.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    localparam int SEL_W = 4;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0]       mode,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        sel = '0;
        case (mode_e'(mode))
            MODE_HOLD: sel[0] = 1'b1;
            MODE_SHR:  sel[1] = 1'b1;
            MODE_SHL:  sel[2] = 1'b1;
            default:   sel[3] = 1'b1;
        endcase
    end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
    import usr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             cur,
    input  logic             from_up,
    input  logic             from_dn,
    input  logic             ld,
    output logic             d
);
    always_comb begin
        d = (sel[0] & cur) | (sel[1] & from_up) | (sel[2] & from_dn) | (sel[3] & ld);
    end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_msb,
    input  logic             ser_in_lsb,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out_lsb,
    output logic             ser_out_msb
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t state_d, state_q;
    logic [SEL_W-1:0] sel;
    logic [WIDTH-1:0] up_src, dn_src, cell_d;

    initial begin
        if (WIDTH < 2) $error("univ_shift_reg: WIDTH must be at least 2");
    end

    usr_mode_dec u_dec (
        .mode (mode),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == TOP) begin : g_top
            assign up_src[i] = ser_in_msb;
        end else begin : g_mid_up
            assign up_src[i] = state_q.bits[i+1];
        end
        if (i == 0) begin : g_bot
            assign dn_src[i] = ser_in_lsb;
        end else begin : g_mid_dn
            assign dn_src[i] = state_q.bits[i-1];
        end
        usr_cell u_cell (
            .sel     (sel),
            .cur     (state_q.bits[i]),
            .from_up (up_src[i]),
            .from_dn (dn_src[i]),
            .ld      (par_in[i]),
            .d       (cell_d[i])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.bits = cell_d;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q           = state_q.bits;
    assign ser_out_lsb = state_q.bits[0];
    assign ser_out_msb = state_q.bits[TOP];

    p_hold_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_HOLD) |=> (q == $past(q)));

    p_shr_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_SHR) |=> (q == {$past(ser_in_msb), $past(q[TOP:1])}));

    p_shl_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_SHL) |=> (q == {$past(q[TOP-1:0]), $past(ser_in_lsb)}));

    p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_LOAD) |=> (q == $past(par_in)));

    always @(posedge clk) begin
        if (!clr_n) begin
            p_clear_r5: assert (q == '0);
        end
    end
endmodule

// File: tb/univ_shift_reg_test.sv
module univ_shift_reg_test;
    localparam int W = 4;

    logic clk = 1'b0;
    logic clr_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sr = 1'b0, sl = 1'b0;
    logic [W-1:0] par = '0;
    logic [W-1:0] q;
    logic so_lsb, so_msb;

    logic [1:0] mode2 = 2'b00;
    logic sr2 = 1'b0, sl2 = 1'b0;
    logic [1:0] par2 = '0;
    logic [1:0] q2;
    logic so2_lsb, so2_msb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    univ_shift_reg #(.WIDTH(W)) uut (
        .clk(clk), .clr_n(clr_n), .mode(mode), .ser_in_msb(sr), .ser_in_lsb(sl),
        .par_in(par), .q(q), .ser_out_lsb(so_lsb), .ser_out_msb(so_msb)
    );

    univ_shift_reg #(.WIDTH(2)) uut2 (
        .clk(clk), .clr_n(clr_n), .mode(mode2), .ser_in_msb(sr2), .ser_in_lsb(sl2),
        .par_in(par2), .q(q2), .ser_out_lsb(so2_lsb), .ser_out_msb(so2_msb)
    );

    // {mode, ser_in_msb, ser_in_lsb, par_in, expected q}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {2'b11, 1'b0, 1'b0, 4'b1011, 4'b1011}, // R4 load
        {2'b00, 1'b1, 1'b1, 4'b0000, 4'b1011}, // R1 hold, R7 ignored inputs
        {2'b01, 1'b0, 1'b1, 4'b1111, 4'b0101}, // R2 shift right, R7
        {2'b01, 1'b1, 1'b0, 4'b0000, 4'b1010}, // R2
        {2'b10, 1'b0, 1'b1, 4'b1111, 4'b0101}, // R3 shift left, R7
        {2'b10, 1'b1, 1'b0, 4'b0000, 4'b1010}, // R3
        {2'b11, 1'b1, 1'b1, 4'b0110, 4'b0110}, // R4, R7
        {2'b10, 1'b1, 1'b0, 4'b1001, 4'b1100}, // R3
        {2'b10, 1'b0, 1'b1, 4'b0000, 4'b1001}, // R3
        {2'b01, 1'b0, 1'b1, 4'b1111, 4'b0100}, // R2
        {2'b00, 1'b1, 1'b0, 4'b1111, 4'b0100}, // R1
        {2'b11, 1'b0, 1'b0, 4'b1111, 4'b1111}  // R4
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12;
        check("R5 reset state", q, '0);
        check("R5 reset state w2", {2'b00, q2}, '0);
        @(negedge clk);
        clr_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {mode, sr, sl, par} = VEC[i][11:4];
            @(posedge clk);
            #1;
            check($sformatf("R1-4/R7 vector %0d", i), q, VEC[i][3:0]);
            check("R6 ser_out_lsb", {3'b000, so_lsb}, {3'b000, VEC[i][0]});
            check("R6 ser_out_msb", {3'b000, so_msb}, {3'b000, VEC[i][3]});
        end

        // R5: clear between edges while in load mode, no clock edge needed
        @(negedge clk);
        mode = 2'b11; par = 4'b1010;
        #2;
        clr_n = 1'b0;
        #1;
        check("R5 async clear", q, '0);
        @(posedge clk);
        #1;
        check("R5 clear overrides load", q, '0);
        @(negedge clk);
        clr_n = 1'b1;
        mode = 2'b00;

        // R8: width 2 ends
        @(negedge clk);
        mode2 = 2'b11; par2 = 2'b01;
        @(posedge clk); #1;
        check("R8 w2 load", {2'b00, q2}, 4'b0001);
        @(negedge clk);
        mode2 = 2'b01; sr2 = 1'b1; sl2 = 1'b0;
        @(posedge clk); #1;
        check("R8 w2 shift right", {2'b00, q2}, 4'b0010);
        @(negedge clk);
        mode2 = 2'b10; sr2 = 1'b0; sl2 = 1'b1;
        @(posedge clk); #1;
        check("R8 w2 shift left", {2'b00, q2}, 4'b0001);
        check("R8 w2 ser outs", {2'b00, so2_msb, so2_lsb}, 4'b0001);
        @(negedge clk);
        mode2 = 2'b00; sr2 = 1'b1; sl2 = 1'b0;
        @(posedge clk); #1;
        check("R8 w2 hold", {2'b00, q2}, 4'b0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule